// File: doc/BRIEF.md
# Serial EEPROM Target with Page Buffer

This block is the device side of a four-wire serial memory link (SPI mode 0: clock idles low, data captured on the rising edge, changed on the falling edge). A host selects it with an active-low select, shifts in an 8-bit command, an address when the command needs one, and data. The block answers from an internal byte array. Reads stream from any start address, with the address advancing on every byte. Writes are collected in a page buffer and copied into the array only when the select line rises cleanly. A status byte reports a write-in-progress flag, a write-enable latch and three protection bits that software can store.

All link inputs are brought into the system clock domain through a synchronizer, so SCK must stay at least a few system clocks in each phase. After a committed write or status write, the block stays busy for `BUSY_CYCLES` system clocks, counted from the cycle in which the rising select is seen. While busy it only answers the status-read command. When `ADDR_BYTES` is 1 and `NINTH_BIT` is set, bit 3 of a read or write command becomes address bit 8, which opens a 512-byte space behind a one-byte address.

The control FSM has these states. `ST_IDLE` waits for select to fall and then goes to `ST_OPCODE`. `ST_OPCODE` takes the command byte and moves on to `ST_ADDR` (read, or write with the latch set), `ST_RDSR` (status read), `ST_WRSR` (status write with the latch set) or `ST_IGNORE` (anything else, or any command except status read while busy). `ST_ADDR` moves to `ST_RDATA` or `ST_WDATA` once the last address byte arrives. `ST_RDATA`, `ST_WDATA`, `ST_RDSR`, `ST_WRSR` and `ST_IGNORE` stay put until select rises. A rising select returns every state to `ST_IDLE`, and this is also the point where a commit happens.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the status byte is 0x00, every array byte reads 0x00, and MISO is low whenever the block is idle with select high.
- R2: Command 0x06 sets the write-enable latch (status bit 1) and command 0x04 clears it. Each takes effect when its command byte completes.
- R3: Command 0x05 returns the status byte MSB first, repeated for every further byte while select stays low. Bit 0 is busy, bit 1 is the latch, bits 3:2 are the protect bits, bit 7 is protect-enable, and bits 6:4 read 0.
- R4: Command 0x03 followed by `ADDR_BYTES` address bytes, most significant byte first, streams array bytes starting at that address. The address advances by one per byte, carries across page boundaries, and wraps from the last array byte to address 0.
- R5: Command 0x02 with the latch set, followed by an address and data bytes, stores the data from the addressed byte onward. Bytes past the end of the page (`PAGE_BYTES`, aligned) wrap to the start of the same page, and nothing is stored until select rises.
- R6: A write (0x02) or status write (0x01) issued with the latch clear changes neither the array nor the status byte.
- R7: A committed write or status write clears the latch.
- R8: After a committed write or status write, status bit 0 reads 1 for `BUSY_CYCLES` clocks. In that window every command except 0x05 is ignored.
- R9: Command 0x01 with the latch set stores data bits 7, 3 and 2 into the protect-enable and protect bits at select rise. All other bits of the data byte are ignored.
- R10: If select rises part-way through a byte, the whole pending write or status write is dropped. The latch stays set and no busy period starts.
- R11: In nine-bit mode (one address byte with `NINTH_BIT`=1), command bit 3 supplies address bit 8: 0x0B reads and 0x0A writes the upper 256 bytes, while 0x03 and 0x02 reach the lower 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, mode 0 |
| mosi | input | 1 | Serial data from the host, MSB first |
| miso | output | 1 | Serial data to the host, MSB first, low when idle |

## Verification
Reads are tried from a single address, as a stream that crosses a page edge, and as a stream that runs off the top of the array. Together these separate a correct increment from one that stops at the page edge or fails to wrap to zero. Writes are tried in several patterns: a short run inside one page, a run that crosses the end of the page, a frame cut mid-byte, and a frame sent with the latch clear. These separate correct in-page wrapping and commit gating from spill-over, partial commits and unguarded commits. The status byte is read right after a commit and again after the busy window, and commands sent inside the window show whether they are blocked. Paired accesses with command bit 3 set and clear, at the same low address byte, show whether address bit 8 is decoded.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_RDSR,
        ST_WRSR,
        ST_IGNORE
    } nvm_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_WRSR,
        CMD_READ,
        CMD_WRITE
    } nvm_cmd_e;

    localparam logic [7:0] OP_SET_LATCH   = 8'h06;
    localparam logic [7:0] OP_CLR_LATCH   = 8'h04;
    localparam logic [7:0] OP_GET_STATUS  = 8'h05;
    localparam logic [7:0] OP_PUT_STATUS  = 8'h01;
    localparam logic [7:0] OP_READ_BYTES  = 8'h03;
    localparam logic [7:0] OP_WRITE_BYTES = 8'h02;

    // In nine-bit mode bit 3 of read/write commands is an address bit.
    function automatic nvm_cmd_e decode_op(input logic [7:0] op, input logic ninth);
        logic [7:0] masked;
        masked = ninth ? (op & 8'hF7) : op;
        if (op == OP_SET_LATCH)        return CMD_WREN;
        if (op == OP_CLR_LATCH)        return CMD_WRDI;
        if (op == OP_GET_STATUS)       return CMD_RDSR;
        if (op == OP_PUT_STATUS)       return CMD_WRSR;
        if (masked == OP_READ_BYTES)   return CMD_READ;
        if (masked == OP_WRITE_BYTES)  return CMD_WRITE;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/nvm_edge_sync.sv
module nvm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    logic [STAGES:0]   cs_sr;
    logic [STAGES:0]   sck_sr;
    logic [STAGES-1:0] mosi_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sr   <= '1;
            sck_sr  <= '0;
            mosi_sr <= '0;
        end else begin
            cs_sr   <= {cs_sr[STAGES-1:0], cs_n};
            sck_sr  <= {sck_sr[STAGES-1:0], sck};
            mosi_sr <= {mosi_sr[STAGES-2:0], mosi};
        end
    end

    // Data is delayed by the same number of stages as the clock edge.
    assign cs_fall  =  cs_sr[STAGES]  & ~cs_sr[STAGES-1];
    assign cs_rise  = ~cs_sr[STAGES]  &  cs_sr[STAGES-1];
    assign sck_rise = ~sck_sr[STAGES] &  sck_sr[STAGES-1];
    assign sck_fall =  sck_sr[STAGES] & ~sck_sr[STAGES-1];
    assign mosi_s   =  mosi_sr[STAGES-1];

endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [OFF_W-1:0]           wr_off,
    input  logic [7:0]                 wr_data,
    output logic [PAGE_BYTES-1:0][7:0] buf_data,
    output logic [PAGE_BYTES-1:0]      buf_valid
);
    for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_slot
        logic [7:0] data_q;
        logic       valid_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q  <= '0;
                valid_q <= 1'b0;
            end else if (clear) begin
                valid_q <= 1'b0;
            end else if (wr_en && wr_off == OFF_W'(k)) begin
                data_q  <= wr_data;
                valid_q <= 1'b1;
            end
        end

        assign buf_data[k]  = data_q;
        assign buf_valid[k] = valid_q;
    end

    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (buf_valid == '0));

    assert_slot_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> buf_valid[$past(wr_off)]);

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
    parameter int BUSY_CYCLES = 300,
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy = (cnt_q != '0);

    assert_busy_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_busy_only_by_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    localparam int ADDR_W = $clog2(MEM_BYTES),
    localparam int PG_W   = ADDR_W - $clog2(PAGE_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [PG_W-1:0]            commit_page,
    input  logic [PAGE_BYTES-1:0][7:0] wdata,
    input  logic [PAGE_BYTES-1:0]      wvalid,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data
);
    logic [7:0] mem_q [MEM_BYTES];

    // A whole page is copied in one cycle, only the slots that were written.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                if (PG_W'(i / PAGE_BYTES) == commit_page && wvalid[i % PAGE_BYTES])
                    mem_q[i] <= wdata[i % PAGE_BYTES];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import nvm_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int ADDR_BYTES  = 1,
    parameter int NINTH_BIT   = 1,
    parameter int BUSY_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int ADDR_W    = $clog2(MEM_BYTES);
    localparam int OFF_W     = $clog2(PAGE_BYTES);
    localparam int PG_W      = ADDR_W - OFF_W;
    localparam int ADDR_BITS = 8 * ADDR_BYTES;
    localparam bit NINTH_EN  = (NINTH_BIT != 0) && (ADDR_BYTES == 1);

    logic cs_fall, cs_rise, sck_rise, sck_fall, mosi_s;

    nvm_state_e state_q, state_d;
    nvm_cmd_e   cmd_q, rx_cmd;
    logic [2:0]           bit_cnt_q;
    logic [6:0]           sh_q;
    logic [1:0]           addr_cnt_q;
    logic [ADDR_BITS-1:0] addr_sh_q, addr_full;
    logic [ADDR_BITS:0]   addr_ext;
    logic [ADDR_W-1:0]    target, rd_addr_q;
    logic [OFF_W-1:0]     wr_off_q;
    logic [PG_W-1:0]      wr_page_q;
    logic                 hi_bit_q, wel_q, wpen_q, sr_have_q;
    logic [1:0]           bp_q;
    logic [2:0]           sr_new_q;
    logic [7:0]           tx_q, rx_byte, status, load_byte, mem_rd;
    logic                 byte_done, last_addr, busy, commit_wr, commit_sr;
    logic [PAGE_BYTES-1:0][7:0] pg_data;
    logic [PAGE_BYTES-1:0]      pg_valid;

    nvm_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s)
    );

    assign rx_byte   = {sh_q, mosi_s};
    assign byte_done = sck_rise && (state_q != ST_IDLE) && (bit_cnt_q == 3'd7);
    assign rx_cmd    = decode_op(rx_byte, NINTH_EN);
    assign last_addr = (addr_cnt_q == 2'(ADDR_BYTES - 1));
    assign addr_full = (addr_sh_q << 8) | ADDR_BITS'(rx_byte);
    assign addr_ext  = {hi_bit_q & NINTH_EN, addr_full};
    assign target    = addr_ext[ADDR_W-1:0];

    assign status    = {wpen_q, 3'b000, bp_q, wel_q, busy};
    assign commit_wr = cs_rise && (state_q == ST_WDATA) && (bit_cnt_q == 3'd0) && (|pg_valid);
    assign commit_sr = cs_rise && (state_q == ST_WRSR) && (bit_cnt_q == 3'd0) && sr_have_q;

    always_comb begin
        unique case (state_q)
            ST_RDSR:  load_byte = status;
            ST_RDATA: load_byte = mem_rd;
            default:  load_byte = 8'h00;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (byte_done) begin
                    case (rx_cmd)
                        CMD_RDSR:  state_d = ST_RDSR;
                        CMD_READ:  state_d = busy ? ST_IGNORE : ST_ADDR;
                        CMD_WRITE: state_d = (busy || !wel_q) ? ST_IGNORE : ST_ADDR;
                        CMD_WRSR:  state_d = (busy || !wel_q) ? ST_IGNORE : ST_WRSR;
                        default:   state_d = ST_IGNORE;
                    endcase
                end
            end
            ST_ADDR: begin
                if (byte_done && last_addr)
                    state_d = (cmd_q == CMD_READ) ? ST_RDATA : ST_WDATA;
            end
            default: ;
        endcase
        if (cs_rise) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= CMD_NONE;
            bit_cnt_q  <= '0;
            sh_q       <= '0;
            addr_cnt_q <= '0;
            addr_sh_q  <= '0;
            rd_addr_q  <= '0;
            wr_off_q   <= '0;
            wr_page_q  <= '0;
            hi_bit_q   <= 1'b0;
            wel_q      <= 1'b0;
            wpen_q     <= 1'b0;
            bp_q       <= '0;
            sr_new_q   <= '0;
            sr_have_q  <= 1'b0;
            tx_q       <= '0;
        end else begin
            if (sck_rise && state_q != ST_IDLE) begin
                sh_q      <= rx_byte[6:0];
                bit_cnt_q <= bit_cnt_q + 3'd1;
            end
            if (byte_done) begin
                case (state_q)
                    ST_OPCODE: begin
                        cmd_q    <= rx_cmd;
                        hi_bit_q <= rx_byte[3];
                        if (!busy) begin
                            if (rx_cmd == CMD_WREN)      wel_q <= 1'b1;
                            else if (rx_cmd == CMD_WRDI) wel_q <= 1'b0;
                        end
                    end
                    ST_ADDR: begin
                        addr_sh_q  <= addr_full;
                        addr_cnt_q <= addr_cnt_q + 2'd1;
                        if (last_addr) begin
                            rd_addr_q <= target;
                            wr_off_q  <= target[OFF_W-1:0];
                            wr_page_q <= target[ADDR_W-1:OFF_W];
                        end
                    end
                    ST_RDATA: rd_addr_q <= rd_addr_q + ADDR_W'(1);
                    ST_WDATA: wr_off_q  <= wr_off_q + OFF_W'(1);
                    ST_WRSR: begin
                        if (!sr_have_q) begin
                            sr_new_q  <= {rx_byte[7], rx_byte[3:2]};
                            sr_have_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            // New byte is presented on the falling edge after a byte boundary.
            if (sck_fall && state_q != ST_IDLE)
                tx_q <= (bit_cnt_q == 3'd0) ? load_byte : {tx_q[6:0], 1'b0};
            if (commit_sr) begin
                wpen_q <= sr_new_q[2];
                bp_q   <= sr_new_q[1:0];
            end
            if (commit_wr || commit_sr) wel_q <= 1'b0;
            if (cs_fall || cs_rise) begin
                bit_cnt_q  <= '0;
                addr_cnt_q <= '0;
                addr_sh_q  <= '0;
                tx_q       <= '0;
                sr_have_q  <= 1'b0;
            end
        end
    end

    assign miso = tx_q[7];

    nvm_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_fall),
        .wr_en     (byte_done && state_q == ST_WDATA),
        .wr_off    (wr_off_q),
        .wr_data   (rx_byte),
        .buf_data  (pg_data),
        .buf_valid (pg_valid)
    );

    nvm_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit_wr),
        .commit_page (wr_page_q),
        .wdata       (pg_data),
        .wvalid      (pg_valid),
        .rd_addr     (rd_addr_q),
        .rd_data     (mem_rd)
    );

    nvm_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit_wr || commit_sr),
        .busy  (busy)
    );

    assert_miso_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !miso);

    assert_commit_needs_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr || commit_sr) |-> wel_q);

    assert_latch_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr || commit_sr) |=> !wel_q);

    assert_no_fill_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA) |-> !busy);

    assert_protect_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_sr |=> $stable({wpen_q, bp_q}));

endmodule

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int MEM        = 512;
    localparam int PAGE       = 16;
    localparam int BUSY       = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] txb [16];
    logic [7:0] rxb [16];
    logic [7:0] st;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_eeprom_slave #(
        .MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .ADDR_BYTES(1),
        .NINTH_BIT(1), .BUSY_CYCLES(BUSY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One frame: nbytes whole bytes plus extra_bits of the following byte.
    task automatic xfer(input int nbytes, input int extra_bits);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < nbytes * 8 + extra_bits; k++) begin
            mosi = txb[k / 8][7 - (k % 8)];
            repeat (HALF) @(negedge clk);
            rxb[k / 8][7 - (k % 8)] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (24) @(negedge clk);
    endtask

    task automatic op1(input logic [7:0] op);
        txb[0] = op;
        xfer(1, 0);
    endtask

    task automatic rdsr(output logic [7:0] s);
        txb[0] = 8'h05; txb[1] = 8'h00;
        xfer(2, 0);
        s = rxb[1];
    endtask

    task automatic rd(input logic [7:0] op, input logic [7:0] a, input int n);
        txb[0] = op; txb[1] = a;
        for (int i = 0; i < n; i++) txb[2 + i] = 8'h00;
        xfer(2 + n, 0);
    endtask

    task automatic wait_idle();
        repeat (BUSY + 40) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 miso idle", {7'b0, miso}, 8'h00);
        rdsr(st);
        check("R1 status after reset", st, 8'h00);
        rd(8'h03, 8'h10, 1);
        check("R1 array after reset", rxb[2], 8'h00);
        check("R1 miso idle after frame", {7'b0, miso}, 8'h00);
    endtask

    task automatic t_latch();
        op1(8'h06);
        rdsr(st);
        check("R2 latch set", st, 8'h02);
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00;
        xfer(3, 0);
        check("R3 status byte 1", rxb[1], 8'h02);
        check("R3 status repeated", rxb[2], 8'h02);
        op1(8'h04);
        rdsr(st);
        check("R2 latch cleared", st, 8'h00);
    endtask

    task automatic t_write_no_latch();
        txb[0] = 8'h02; txb[1] = 8'h20; txb[2] = 8'hAA;
        xfer(3, 0);
        rdsr(st);
        check("R6 no busy after unlatched write", st, 8'h00);
        rd(8'h03, 8'h20, 1);
        check("R6 array untouched", rxb[2], 8'h00);
    endtask

    task automatic t_write_commit();
        op1(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h20;
        txb[2] = 8'h11; txb[3] = 8'h22; txb[4] = 8'h33;
        xfer(5, 0);
        rdsr(st);
        check("R7 R8 busy set, latch cleared", st, 8'h01);
        wait_idle();
        rdsr(st);
        check("R8 busy ends", st, 8'h00);
        rd(8'h03, 8'h1F, 5);
        check("R4 byte before", rxb[2], 8'h00);
        check("R5 stored 0", rxb[3], 8'h11);
        check("R5 stored 1", rxb[4], 8'h22);
        check("R5 stored 2", rxb[5], 8'h33);
        check("R4 byte after", rxb[6], 8'h00);
    endtask

    task automatic t_busy_ignore();
        op1(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h60; txb[2] = 8'h44;
        xfer(3, 0);
        op1(8'h06);
        wait_idle();
        rdsr(st);
        check("R8 latch command ignored while busy", st, 8'h00);
        rd(8'h03, 8'h60, 1);
        check("R5 single byte", rxb[2], 8'h44);
    endtask

    task automatic t_page_wrap();
        op1(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h3E;
        txb[2] = 8'hA0; txb[3] = 8'hA1; txb[4] = 8'hA2; txb[5] = 8'hA3;
        xfer(6, 0);
        wait_idle();
        rd(8'h03, 8'h3E, 3);
        check("R4 read 3E", rxb[2], 8'hA0);
        check("R4 read 3F", rxb[3], 8'hA1);
        check("R5 no spill into 40", rxb[4], 8'h00);
        rd(8'h03, 8'h30, 2);
        check("R5 wrapped to 30", rxb[2], 8'hA2);
        check("R5 wrapped to 31", rxb[3], 8'hA3);
    endtask

    task automatic t_status_write();
        txb[0] = 8'h01; txb[1] = 8'hFF;
        xfer(2, 0);
        rdsr(st);
        check("R6 status write without latch", st, 8'h00);
        op1(8'h06);
        txb[0] = 8'h01; txb[1] = 8'hFF;
        xfer(2, 0);
        rdsr(st);
        check("R9 R8 protect stored, busy", st, 8'h8D);
        wait_idle();
        rdsr(st);
        check("R9 protect kept", st, 8'h8C);
        op1(8'h06);
        txb[0] = 8'h01; txb[1] = 8'h00;
        xfer(2, 0);
        wait_idle();
        rdsr(st);
        check("R9 protect cleared", st, 8'h00);
    endtask

    task automatic t_partial();
        op1(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h50; txb[2] = 8'h77; txb[3] = 8'hF0;
        xfer(3, 4);
        rdsr(st);
        check("R10 latch kept, no busy", st, 8'h02);
        rd(8'h03, 8'h50, 1);
        check("R10 nothing stored", rxb[2], 8'h00);
        op1(8'h04);
        rdsr(st);
        check("R2 latch cleared again", st, 8'h00);
    endtask

    task automatic t_ninth();
        op1(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'hE7;
        xfer(3, 0);
        wait_idle();
        op1(8'h06);
        txb[0] = 8'h0A; txb[1] = 8'hFF; txb[2] = 8'h5A;
        xfer(3, 0);
        wait_idle();
        rd(8'h0B, 8'hFF, 2);
        check("R11 upper byte 1FF", rxb[2], 8'h5A);
        check("R4 wrap to address 0", rxb[3], 8'hE7);
        rd(8'h03, 8'hFF, 1);
        check("R11 lower byte 0FF", rxb[2], 8'h00);
        op1(8'h06);
        txb[0] = 8'h0A; txb[1] = 8'h00; txb[2] = 8'hC3;
        xfer(3, 0);
        wait_idle();
        rd(8'h0B, 8'h00, 1);
        check("R11 upper byte 100", rxb[2], 8'hC3);
        rd(8'h03, 8'h00, 1);
        check("R11 lower byte 000", rxb[2], 8'hE7);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_latch();
        t_write_no_latch();
        t_write_commit();
        t_busy_ignore();
        t_page_wrap();
        t_status_write();
        t_partial();
        t_ninth();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule